// File: doc/BRIEF.md
# DMA Address Remapping Walker

This block stands between I/O devices and system memory and decides, for each DMA request, where it may go. A request carries a 16-bit requester identifier, a 48-bit device-side address and a direction flag. The block first resolves the requester to its translation context: the bus number selects an entry in a root table, and the device/function number selects an entry in the context table that the root entry points to. The context entry then either grants the address unchanged or names the top of a four-level page table. The block walks that table to a 4 KB page frame, or it refuses the request with a fault code.

Table entries are read one 64-bit word at a time through a memory read port. The port answers each read after a latency that can change from read to read. Two software-visible settings sit in a small register interface: the root table base address and a global enable. While the enable is clear, the block returns every request untranslated and issues no memory reads. The block handles one request at a time. The request port stays not-ready from acceptance until the result has been shown for one cycle.

Top module: `dma_remap_walker`

## Requirements
- R1: The requester identifier splits into bus (bits 15:8) and device/function (bits 7:0). The first read of a translated request is at address root_base + bus*16. A root entry is present when bit 0 is 1, and its bits 47:12 give the 4 KB-aligned context table address.
- R2: The second read is at context_table + devfn*16. A context entry is present when bit 0 is 1. Its bits 3:2 hold the translation type, and its bits 47:12 give the 4 KB-aligned address of the top page table.
- R3: With translation type 2'b00, the block reads four page-table levels. It indexes them with address bits 47:39, 38:30, 29:21 and 20:12, each at table + index*8. Each entry's bits 47:12 point to the next table, and at the last level to the page frame. The result address is {frame bits 47:12, input bits 11:0}, with no fault, after exactly six reads.
- R4: While the enable is 0, a request completes with the output address equal to the input address, no fault, and no memory read.
- R5: Translation type 2'b10 grants the request with output address equal to input address, no fault, after exactly two reads.
- R6: A root entry with bit 0 clear ends the request with fault code 1 after one read. A context entry with bit 0 clear ends it with fault code 2 after two reads.
- R7: Translation type 2'b01 or 2'b11 in a present context entry ends the request with fault code 3 after two reads.
- R8: Page-table entries grant read in bit 0 and write in bit 1. If the entry at any level lacks the bit for the request's direction, the walk stops at that level with fault code 4. A faulting response reports address 0, and a successful one reports code 0.
- R9: req_ready falls in the cycle after acceptance and stays low until the result. The result is held on rsp_valid for exactly one cycle, and req_ready is high again in the next cycle.
- R10: The root base and the enable are captured when a request is accepted. Register writes during a walk do not affect that walk, but they do apply to the next request. Register select 0 writes the base from reg_wdata, and select 1 writes the enable from reg_wdata bit 0.
- R11: After reset, req_ready is 1, rsp_valid and mem_req are 0, the enable is 0 and the root base is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects root base, 1 selects enable |
| reg_wdata | input | 48 | Register write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_rid | input | 16 | Requester identifier (bus, device, function) |
| req_addr | input | 48 | Device-side address |
| req_write | input | 1 | 1 for write, 0 for read |
| mem_req | output | 1 | One-cycle table read request |
| mem_addr | output | 48 | Byte address of the table word |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 64 | Table word |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_paddr | output | 48 | Translated address (0 on fault) |
| rsp_fault | output | 1 | Request refused |
| rsp_code | output | 3 | Fault reason (0 none, 1 root, 2 context, 3 type, 4 permission) |

## Verification
The assertions assume that the memory port returns exactly one mem_rvalid for each mem_req, never before the cycle after the request and never while no read is pending. The bench's memory responder follows this. It captures each read request at the falling edge and answers one to four cycles later with a single strobe, with the delay rotating from read to read. Requests are driven only while req_ready is high. Register writes, including those made on purpose in the middle of a walk, use the documented select encoding.

// File: rtl/dma_remap_walker.sv
module dma_remap_walker #(
  parameter int AW   = 48,
  parameter int DW   = 64,
  parameter int RIDW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [AW-1:0] reg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [RIDW-1:0] req_rid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_paddr,
  output logic          rsp_fault,
  output logic [2:0]    rsp_code
);
  localparam int OFFW = 12;
  localparam int IDXW = 9;
  localparam int BUSW = RIDW / 2;
  localparam logic [2:0] P_ROOT = 3'd0, P_CTX = 3'd1, P_L0 = 3'd2, P_LEAF = 3'd5;
  localparam logic [2:0] F_NONE = 3'd0, F_ROOT = 3'd1, F_CTX = 3'd2, F_TYPE = 3'd3, F_PERM = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_RESP} st_t;
  st_t st;

  logic [AW-1:0]   base_r, base_q, va_q, ptr_q, pa_q;
  logic            en_r, en_q, wr_q, fault_q;
  logic [RIDW-1:0] rid_q;
  logic [2:0]      phase_q, code_q;
  logic [IDXW-1:0] idx;
  logic [AW-1:0]   fetch_addr, ent_ptr;
  logic            ent_present, ent_perm;
  logic [1:0]      ent_tt;
  logic            unused_bits;

  assign ent_present = mem_rdata[0];
  assign ent_tt      = mem_rdata[3:2];
  assign ent_perm    = wr_q ? mem_rdata[1] : mem_rdata[0];
  assign ent_ptr     = {mem_rdata[AW-1:OFFW], {OFFW{1'b0}}};
  assign unused_bits = ^{mem_rdata[DW-1:AW], mem_rdata[OFFW-1:4]};

  always_comb begin
    case (phase_q)
      3'd2:    idx = va_q[OFFW+4*IDXW-1 -: IDXW];
      3'd3:    idx = va_q[OFFW+3*IDXW-1 -: IDXW];
      3'd4:    idx = va_q[OFFW+2*IDXW-1 -: IDXW];
      default: idx = va_q[OFFW+IDXW-1 -: IDXW];
    endcase
    case (phase_q)
      P_ROOT:  fetch_addr = base_q + {{(AW-BUSW-4){1'b0}}, rid_q[RIDW-1:BUSW], 4'b0};
      P_CTX:   fetch_addr = ptr_q + {{(AW-BUSW-4){1'b0}}, rid_q[BUSW-1:0], 4'b0};
      default: fetch_addr = ptr_q + {{(AW-IDXW-3){1'b0}}, idx, 3'b0};
    endcase
  end

  assign req_ready = (st == S_IDLE);
  assign mem_req   = (st == S_FETCH);
  assign mem_addr  = fetch_addr;
  assign rsp_valid = (st == S_RESP);
  assign rsp_paddr = pa_q;
  assign rsp_fault = fault_q;
  assign rsp_code  = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      base_r <= '0; en_r <= 1'b0;
      base_q <= '0; en_q <= 1'b0;
      va_q <= '0; ptr_q <= '0; pa_q <= '0;
      rid_q <= '0; wr_q <= 1'b0;
      phase_q <= P_ROOT; fault_q <= 1'b0; code_q <= F_NONE;
    end else begin
      if (reg_wr) begin
        if (reg_sel) en_r <= reg_wdata[0];
        else         base_r <= reg_wdata;
      end
      case (st)
        S_IDLE: if (req_valid) begin
          rid_q <= req_rid; va_q <= req_addr; wr_q <= req_write;
          base_q <= base_r; en_q <= en_r;
          phase_q <= P_ROOT; fault_q <= 1'b0; code_q <= F_NONE;
          if (en_r) st <= S_FETCH;
          else begin
            pa_q <= req_addr;
            st <= S_RESP;
          end
        end
        S_FETCH: st <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          if (phase_q == P_ROOT) begin
            if (!ent_present) begin
              fault_q <= 1'b1; code_q <= F_ROOT; pa_q <= '0; st <= S_RESP;
            end else begin
              ptr_q <= ent_ptr; phase_q <= P_CTX; st <= S_FETCH;
            end
          end else if (phase_q == P_CTX) begin
            if (!ent_present) begin
              fault_q <= 1'b1; code_q <= F_CTX; pa_q <= '0; st <= S_RESP;
            end else if (ent_tt == 2'b00) begin
              ptr_q <= ent_ptr; phase_q <= P_L0; st <= S_FETCH;
            end else if (ent_tt == 2'b10) begin
              pa_q <= va_q; st <= S_RESP;
            end else begin
              fault_q <= 1'b1; code_q <= F_TYPE; pa_q <= '0; st <= S_RESP;
            end
          end else begin
            if (!ent_perm) begin
              fault_q <= 1'b1; code_q <= F_PERM; pa_q <= '0; st <= S_RESP;
            end else if (phase_q == P_LEAF) begin
              pa_q <= {ent_ptr[AW-1:OFFW], va_q[OFFW-1:0]}; st <= S_RESP;
            end else begin
              ptr_q <= ent_ptr; phase_q <= phase_q + 3'd1; st <= S_FETCH;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r9_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
  a_r1_single_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r4_no_read_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> en_q);
  a_r4_identity_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !en_q) |-> (rsp_paddr == va_q && !rsp_fault));
  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFFW-1:0] == va_q[OFFW-1:0]));
  a_r8_code_matches_fault: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault == (rsp_code != F_NONE)));
  a_r10_captured_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !rsp_valid) |=> ($stable(base_q) && $stable(en_q)));
endmodule

// File: tb/dma_remap_walker_test.sv
`timescale 1ns/1ps
module dma_remap_walker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [47:0] reg_wdata = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_rid = '0;
  logic [47:0] req_addr = '0;
  logic req_ready, mem_req, rsp_valid, rsp_fault;
  logic [47:0] mem_addr, rsp_paddr;
  logic mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic [2:0] rsp_code;

  always #2.5 clk = ~clk;

  dma_remap_walker uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_rid(req_rid), .req_addr(req_addr),
    .req_write(req_write), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_code(rsp_code));

  typedef struct packed {
    logic        fault;
    logic [2:0]  code;
    logic [47:0] pa;
    logic [31:0] reads;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  logic [63:0] mem [logic [47:0]];
  int checks = 0, failures = 0, rd_cnt = 0;
  logic [47:0] next_page = 48'h0000_2000_0000;
  logic [47:0] root_base = 48'h0000_1000_0000;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [63:0] rdmem(input logic [47:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic logic [47:0] alloc();
    logic [47:0] p = next_page;
    next_page = next_page + 48'h1000;
    return p;
  endfunction

  // perms: {L3,L2,L1,L0} two bits each (bit0 read, bit1 write); tt at context bits 3:2
  task automatic map_walk(input logic [15:0] rid, input logic [47:0] va,
                          input logic [1:0] tt, input logic [7:0] perms,
                          input logic [47:0] leaf);
    logic [47:0] ctab = alloc();
    logic [47:0] t = alloc();
    logic [47:0] nxt;
    mem[root_base + {32'h0, rid[15:8], 4'h0}] = {16'h0, ctab} | 64'h1;
    mem[ctab + {32'h0, rid[7:0], 4'h0}] = {16'h0, t} | {60'h0, tt, 2'b01};
    for (int l = 0; l < 4; l++) begin
      logic [8:0] ix = va[47 - 9*l -: 9];
      nxt = (l == 3) ? leaf : alloc();
      mem[t + {36'h0, ix, 3'b0}] = {16'h0, nxt} | {62'h0, perms[2*l +: 2]};
      t = nxt;
    end
  endtask

  task automatic reg_write(input logic sel, input logic [47:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic send(input logic [15:0] rid, input logic [47:0] va, input logic wr,
                      input logic f, input logic [2:0] code, input logic [47:0] pa,
                      input int reads, input string tag);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    e.fault = f; e.code = code; e.pa = pa; e.reads = reads;
    exp_q.push_back(e); tag_q.push_back(tag);
    rd_cnt = 0;
    req_valid = 1'b1; req_rid = rid; req_addr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9", "ready after accept", {63'h0, req_ready}, 64'h0);
  endtask

  // memory responder: one answer per read, 1..4 cycles later
  initial begin
    int cnt = 0;
    int rot = 0;
    logic [47:0] pend_a = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata = rdmem(pend_a);
        end
      end
      if (mem_req) begin
        rd_cnt++;
        pend_a = mem_addr;
        cnt = 1 + (rot % 4);
        rot++;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        exp_t e;
        string tg;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected response", 64'h1, 64'h0);
        end else begin
          e = exp_q.pop_front(); tg = tag_q.pop_front();
          chk(rsp_fault == e.fault, tg, "fault", {63'h0, rsp_fault}, {63'h0, e.fault});
          chk(rsp_code == e.code, tg, "code", {61'h0, rsp_code}, {61'h0, e.code});
          chk(rsp_paddr == e.pa, tg, "paddr", {16'h0, rsp_paddr}, {16'h0, e.pa});
          chk(rd_cnt == int'(e.reads), tg, "reads", 64'(rd_cnt), {32'h0, e.reads});
        end
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R9", "one-cycle result",
            {62'h0, rsp_valid, req_ready}, 64'h1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [47:0] va;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready == 1'b1, "R11", "ready in reset", {63'h0, req_ready}, 64'h1);
    chk(!rsp_valid && !mem_req, "R11", "idle outputs", {62'h0, rsp_valid, mem_req}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && !rsp_valid && !mem_req, "R11", "after reset",
        {61'h0, req_ready, rsp_valid, mem_req}, 64'h4);

    // R4 / R11: enable resets to 0
    send(16'h0508, 48'h1234_5678_9ABC, 1'b0, 1'b0, 3'd0, 48'h1234_5678_9ABC, 0, "R4");
    send(16'h0100, 48'hFFFF_0000_0123, 1'b1, 1'b0, 3'd0, 48'hFFFF_0000_0123, 0, "R11");

    reg_write(1'b0, root_base);
    reg_write(1'b1, 48'h1);

    // R1 R2 R3 full read walk
    va = 48'h8123_4567_8ABC;
    map_walk(16'h0500, va, 2'b00, 8'b01_01_01_01, 48'h0000_7777_7000);
    send(16'h0500, va, 1'b0, 1'b0, 3'd0, {36'h0000_7777_7, va[11:0]}, 6, "R1");

    va = 48'h0042_C0DE_1F00;
    map_walk(16'h03A5, va, 2'b00, 8'b11_11_11_11, 48'h0000_ABCD_E000);
    send(16'h03A5, va, 1'b1, 1'b0, 3'd0, {36'h0000_ABCD_E, va[11:0]}, 6, "R3");
    send(16'h03A5, va, 1'b0, 1'b0, 3'd0, {36'h0000_ABCD_E, va[11:0]}, 6, "R2");

    // R8 permission faults
    va = 48'h7FFF_FFFF_F004;
    map_walk(16'h0600, va, 2'b00, 8'b01_11_11_11, 48'h0000_1111_1000);
    send(16'h0600, va, 1'b1, 1'b1, 3'd4, 48'h0, 6, "R8");
    send(16'h0600, va, 1'b0, 1'b0, 3'd0, {36'h0000_1111_1, va[11:0]}, 6, "R8");
    va = 48'h0000_4020_1008;
    map_walk(16'h0811, va, 2'b00, 8'b01_01_10_01, 48'h0000_2222_2000);
    send(16'h0811, va, 1'b0, 1'b1, 3'd4, 48'h0, 4, "R8");

    // R5 pass-through type
    va = 48'hDEAD_BEEF_0123;
    map_walk(16'h07FF, va, 2'b10, 8'h00, 48'h0);
    send(16'h07FF, va, 1'b1, 1'b0, 3'd0, va, 2, "R5");

    // R7 reserved types
    map_walk(16'h0901, va, 2'b01, 8'hFF, 48'h0000_3333_3000);
    send(16'h0901, va, 1'b0, 1'b1, 3'd3, 48'h0, 2, "R7");
    map_walk(16'h0A02, va, 2'b11, 8'hFF, 48'h0000_3333_3000);
    send(16'h0A02, va, 1'b0, 1'b1, 3'd3, 48'h0, 2, "R7");

    // R6 non-present entries
    send(16'h2000, va, 1'b0, 1'b1, 3'd1, 48'h0, 1, "R6");
    mem[root_base + {32'h0, 8'h21, 4'h0}] = {16'h0, alloc()} | 64'h1;
    send(16'h2133, va, 1'b0, 1'b1, 3'd2, 48'h0, 2, "R6");

    // R10 writes during a walk
    va = 48'h8123_4567_8ABC;
    send(16'h0500, va, 1'b0, 1'b0, 3'd0, {36'h0000_7777_7, va[11:0]}, 6, "R10");
    reg_write(1'b0, 48'h0000_DEAD_0000);
    reg_write(1'b1, 48'h0);
    send(16'h0500, va, 1'b0, 1'b0, 3'd0, va, 0, "R10");
    reg_write(1'b0, root_base);
    reg_write(1'b1, 48'h1);
    send(16'h0500, va, 1'b1, 1'b1, 3'd4, 48'h0, 3, "R10");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule